// File: doc/BRIEF.md
# Dual-Channel Pixel Concentrator

This block gathers 12-bit pixel words from five upstream segment-finder sources and sends them out on two channels. Each source delivers a word together with a valid strobe. Channel 0 serves sources 0, 1 and 2, and channel 1 serves sources 2, 3 and 4. Source 2 sits in both groups, so every one of its words is queued once for each channel.

Each channel keeps one queue per source. When all three of a channel's queues hold at least six words, the channel sends a burst of 18 slices, one per clock: first the six oldest words of its lowest-numbered source, then the middle source, then the highest. A first-slice flag marks the start of every burst. A write into a full queue is discarded and sets a sticky error flag for that channel.

Top module: `pixel_concentrator`

## Requirements
- R1: While reset is high, and in the first cycle after it, every channel valid, first-slice and overflow output is 0.
- R2: Channel 0 carries words from sources 0, 1 and 2 only, and channel 1 from sources 2, 3 and 4 only. Each word from source 2 appears once on each channel.
- R3: A channel starts no burst until each of its three source queues holds at least six words.
- R4: If the word that completes a channel's readiness is captured at clock edge k, slice 0 of that channel's burst is valid after edge k+2 and not before.
- R5: A burst is 18 consecutive valid cycles. Slices 0-5 are the six oldest queued words of the channel's lowest-numbered source, slices 6-11 come from its middle source and slices 12-17 from its highest, each group in arrival order.
- R6: The first-slice flag is high together with slice 0 of each burst and low on every other cycle.
- R7: Between two bursts of the same channel, valid is low for at least one cycle.
- R8: A queue holds 16 words. A write to a full queue is dropped and sets that channel's overflow bit (bit 0 for channel 0, bit 1 for channel 1). The bit stays set until reset. Filling a queue to exactly 16 words sets no error.
- R9: The two channels run independently. One channel can burst while the other waits, even when the waiting channel holds source 2's words.
- R10: Words beyond six per source stay queued for later bursts. Writes made while a burst is running are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | 60 | Pixel words; source s is in bits [12s+11:12s] |
| src_valid | input | 5 | Write strobe per source |
| ch_word | output | 24 | Output slice; channel c is in bits [12c+11:12c] |
| ch_valid | output | 2 | Slice valid per channel |
| ch_first | output | 2 | High on slice 0 of a burst, per channel |
| ch_ovf | output | 2 | Sticky overflow flag per channel |

## Verification
The assertions check the burst shape on every cycle. They confirm that a valid run never passes 18 cycles and that it always ends at exactly 18. They also confirm that the first-slice flag comes only at the rising edge of valid after an idle cycle, and that an overflow bit never clears on its own. Other behaviour can only be shown by the bench's scenarios: which words arrive and in which order, the sharing of source 2, the two-cycle start latency, and keeping the channels independent while one waits. The bench checks these with a scoreboard that predicts every slice from the words it has written.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pxc_state_e;
endpackage

// File: rtl/pxc_fifo.sv
module pxc_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] fill,
  output logic          drop
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign do_wr   = wr_en && (cnt_q != FULL);
  assign do_rd   = rd_en && (cnt_q != '0);
  assign drop    = wr_en && (cnt_q == FULL);
  assign rd_data = mem[rd_ptr];
  assign fill    = cnt_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pxc_ctrl.sv
module pxc_ctrl #(
  parameter int NSRC  = 3,
  parameter int CELLS = 6,
  parameter int CW    = 5,
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int LW   = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC*CW-1:0] fill,
  output logic [NSRC-1:0]    rd_sel,
  output logic [SW-1:0]      src,
  output logic               run,
  output logic               slice0
);
  import pxc_pkg::*;

  localparam logic [CW-1:0] NEED     = CW'(CELLS);
  localparam logic [LW-1:0] LAST_LN  = LW'(CELLS - 1);
  localparam logic [SW-1:0] LAST_SRC = SW'(NSRC - 1);

  pxc_state_e    state_q;
  logic [SW-1:0] src_q;
  logic [LW-1:0] cell_q;
  logic [NSRC-1:0] enough;

  for (genvar k = 0; k < NSRC; k++) begin : g_need
    assign enough[k] = fill[k*CW +: CW] >= NEED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      cell_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          src_q  <= '0;
          cell_q <= '0;
          if (&enough) state_q <= ST_RUN;
        end
        default: begin
          if (cell_q == LAST_LN) begin
            cell_q <= '0;
            if (src_q == LAST_SRC) begin
              src_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              src_q <= src_q + 1'b1;
            end
          end else begin
            cell_q <= cell_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign run    = (state_q == ST_RUN);
  assign src    = src_q;
  assign slice0 = run && (src_q == '0) && (cell_q == '0);

  always_comb begin
    rd_sel = '0;
    if (run) rd_sel[src_q] = 1'b1;
  end
endmodule

// File: rtl/pxc_chan.sv
module pxc_chan #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  parameter int NSRC  = 3,
  parameter int CELLS = 6,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC*W-1:0] in_data,
  input  logic [NSRC-1:0]   in_valid,
  output logic [W-1:0]      out_data,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_ovf
);
  logic [W-1:0]       rd_word [NSRC];
  logic [NSRC*CW-1:0] fill;
  logic [NSRC-1:0]    rd_sel, drop;
  logic [SW-1:0]      src;
  logic               run, slice0;

  for (genvar k = 0; k < NSRC; k++) begin : g_q
    pxc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (in_valid[k]),
      .wr_data (in_data[k*W +: W]),
      .rd_en   (rd_sel[k]),
      .rd_data (rd_word[k]),
      .fill    (fill[k*CW +: CW]),
      .drop    (drop[k])
    );
  end

  pxc_ctrl #(.NSRC(NSRC), .CELLS(CELLS), .CW(CW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .fill   (fill),
    .rd_sel (rd_sel),
    .src    (src),
    .run    (run),
    .slice0 (slice0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_ovf   <= 1'b0;
    end else begin
      out_data  <= run ? rd_word[src] : '0;
      out_valid <= run;
      out_first <= slice0;
      if (|drop) out_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pixel_concentrator.sv
module pixel_concentrator #(
  parameter int W           = 12,
  parameter int DEPTH       = 16,
  parameter int CELLS       = 6,
  parameter int SRCS_PER_CH = 3,
  parameter int NUM_CH      = 2,
  localparam int NUM_SRC    = NUM_CH * (SRCS_PER_CH - 1) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC*W-1:0] src_word,
  input  logic [NUM_SRC-1:0]  src_valid,
  output logic [NUM_CH*W-1:0] ch_word,
  output logic [NUM_CH-1:0]   ch_valid,
  output logic [NUM_CH-1:0]   ch_first,
  output logic [NUM_CH-1:0]   ch_ovf
);
  // neighbouring channels share their boundary source
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = c * (SRCS_PER_CH - 1);
    pxc_chan #(.W(W), .DEPTH(DEPTH), .NSRC(SRCS_PER_CH), .CELLS(CELLS)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .in_data   (src_word[BASE*W +: SRCS_PER_CH*W]),
      .in_valid  (src_valid[BASE +: SRCS_PER_CH]),
      .out_data  (ch_word[c*W +: W]),
      .out_valid (ch_valid[c]),
      .out_first (ch_first[c]),
      .out_ovf   (ch_ovf[c])
    );
  end
endmodule

// File: rtl/pxc_chk.sv
module pxc_chk #(
  parameter int NUM_CH = 2,
  parameter int CELLS  = 6,
  parameter int SRCS   = 3,
  localparam int BURST = CELLS * SRCS,
  localparam int RW    = $clog2(BURST + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_valid,
  input logic [NUM_CH-1:0] ch_first,
  input logic [NUM_CH-1:0] ch_ovf
);
  localparam logic [RW-1:0] BLEN = RW'(BURST);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst) run_q <= '0;
      else     run_q <= ch_valid[c] ? run_q + 1'b1 : '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!ch_valid[c] && !ch_first[c] && !ch_ovf[c]));

    a_r5_burst_bounded: assert property (@(posedge clk) disable iff (rst)
      ch_valid[c] |-> (run_q < BLEN));

    a_r5_burst_full: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_valid[c]) |-> (run_q == BLEN));

    a_r6_first_on_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_valid[c]) |-> ch_first[c]);

    a_r6_first_only_start: assert property (@(posedge clk) disable iff (rst)
      ch_first[c] |-> (ch_valid[c] && run_q == '0));

    a_r7_idle_gap: assert property (@(posedge clk) disable iff (rst)
      ch_first[c] |-> !$past(ch_valid[c]));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      ch_ovf[c] |=> ch_ovf[c]);
  end
endmodule

bind pixel_concentrator pxc_chk #(
  .NUM_CH (NUM_CH),
  .CELLS  (CELLS),
  .SRCS   (SRCS_PER_CH)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ch_valid (ch_valid),
  .ch_first (ch_first),
  .ch_ovf   (ch_ovf)
);

// File: tb/pixel_concentrator_tb_top.sv
module pixel_concentrator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12, DEPTH = 16, CELLS = 6, NS = 5, NC = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [NS*W-1:0] src_word;
  logic [NS-1:0]   src_valid;
  logic [NC*W-1:0] ch_word;
  logic [NC-1:0]   ch_valid, ch_first, ch_ovf;

  int n_tests = 0, n_fail = 0;
  int seqn [NS];
  logic [W-1:0] srcq [NC*3][$];
  logic [W:0]   exp_q [NC][$];
  logic [NC-1:0] prev_v;
  int run_len [NC];
  logic [W:0] mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_concentrator dut_i (
    .clk(clk), .rst(rst), .src_word(src_word), .src_valid(src_valid),
    .ch_word(ch_word), .ch_valid(ch_valid), .ch_first(ch_first), .ch_ovf(ch_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard model: queue per channel/source, drained in whole bursts
  task automatic model_write(input int s, input logic [W-1:0] w);
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 3; k++)
        if (2*c + k == s && srcq[c*3+k].size() < DEPTH) srcq[c*3+k].push_back(w);
    for (int c = 0; c < NC; c++)
      if (srcq[c*3].size() >= CELLS && srcq[c*3+1].size() >= CELLS && srcq[c*3+2].size() >= CELLS)
        for (int k = 0; k < 3; k++)
          for (int i = 0; i < CELLS; i++)
            exp_q[c].push_back({(k == 0 && i == 0), srcq[c*3+k].pop_front()});
  endtask

  // driver: called at a falling edge, returns at the falling edge after capture
  task automatic push(input logic [NS-1:0] mask);
    for (int s = 0; s < NS; s++) begin
      if (mask[s]) begin
        logic [W-1:0] w;
        w = {s[2:0], seqn[s][8:0]};
        seqn[s]++;
        src_word[s*W +: W] = w;
        src_valid[s] = 1'b1;
        model_write(s, w);
      end
    end
    @(posedge clk);
    @(negedge clk);
    src_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    src_valid = '0;
    for (int i = 0; i < NC*3; i++) srcq[i].delete();
    for (int c = 0; c < NC; c++) exp_q[c].delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst) begin
      prev_v = '0;
      for (int c = 0; c < NC; c++) run_len[c] = 0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (ch_valid[c]) begin
          run_len[c]++;
          chk(run_len[c] <= 3*CELLS, "R5 burst length", run_len[c], 3*CELLS);
          chk(!(ch_first[c] && prev_v[c]), "R7 gap before burst", prev_v[c], 0);
          if (exp_q[c].size() == 0) begin
            chk(0, "R2 unexpected slice", ch_word[c*W +: W], 0);
          end else begin
            mon_e = exp_q[c].pop_front();
            chk(ch_word[c*W +: W] == mon_e[W-1:0], "R2/R5 slice data", ch_word[c*W +: W], mon_e[W-1:0]);
            chk(ch_first[c] == mon_e[W], "R6 first flag", ch_first[c], mon_e[W]);
          end
        end else begin
          run_len[c] = 0;
          chk(!ch_first[c], "R6 first without valid", ch_first[c], 0);
        end
      end
      prev_v = ch_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) seqn[s] = 0;
    src_word = '0;
    do_reset();
    chk(ch_valid == '0, "R1 valid after reset", ch_valid, 0);
    chk(ch_first == '0, "R1 first after reset", ch_first, 0);
    chk(ch_ovf == '0, "R1 ovf after reset", ch_ovf, 0);

    // all sources at once: both channels, source 2 shared
    repeat (6) push(5'b11111);
    idle(50);
    // twelve more each, continuous: second burst queued behind first (R10)
    repeat (12) push(5'b11111);
    idle(80);
    chk(exp_q[0].size() == 0, "R10 channel 0 drained", exp_q[0].size(), 0);
    chk(exp_q[1].size() == 0, "R10 channel 1 drained", exp_q[1].size(), 0);

    // latency and independence
    do_reset();
    repeat (6) push(5'b11000);
    repeat (5) push(5'b00100);
    idle(5);
    chk(ch_valid == '0, "R3 no burst with five words", ch_valid, 0);
    push(5'b00100);
    chk(!ch_valid[1], "R4 not at k", ch_valid[1], 0);
    idle(1);
    chk(!ch_valid[1], "R4 not at k+1", ch_valid[1], 0);
    idle(1);
    chk(ch_valid[1] && ch_first[1], "R4 slice0 at k+2", {ch_valid[1], ch_first[1]}, 2'b11);
    chk(!ch_valid[0], "R9 channel 0 waits", ch_valid[0], 0);
    idle(30);
    repeat (6) push(5'b00011);
    idle(40);
    chk(exp_q[0].size() == 0, "R9 channel 0 burst delivered", exp_q[0].size(), 0);
    chk(exp_q[1].size() == 0, "R9 channel 1 burst delivered", exp_q[1].size(), 0);

    // overflow
    do_reset();
    repeat (16) push(5'b00001);
    chk(ch_ovf == '0, "R8 full queue no error", ch_ovf, 0);
    push(5'b00001);
    chk(ch_ovf == 2'b01, "R8 overflow on channel 0", ch_ovf, 2'b01);
    repeat (6) push(5'b00110);
    idle(40);
    chk(ch_ovf == 2'b01, "R8 overflow sticky", ch_ovf, 2'b01);
    chk(exp_q[0].size() == 0, "R8 oldest words survive", exp_q[0].size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule